// File: doc/BRIEF.md
# Auto-Transfer Synchronous Serial Master

This block is a master-only clocked serial shifter. Software or a neighbouring engine sets a transfer length in bits, a bit order and a clock divider, then pulses a start command. From then on the block runs the whole transfer by itself. At each byte boundary it pulls the next transmit byte over a valid/ready handshake and hands back each received byte with a one-cycle strobe. Nobody has to service it between bytes.

The serial clock is made by an internal divide-by-N counter whose setting is clamped to a minimum, so that the fastest rate stays legal. The clock idles high. Output data changes on the falling edge and input data is captured on the rising edge. A transfer may be any length from 1 to 256 bits, so the last byte can be partial. A pause input, or a missing transmit byte, freezes the clock at the next byte boundary. Shifting resumes once both clear, and no bit is lost or repeated.

Top module: `ssp_autoxfer`

## Requirements
- R1: After reset, `sclk` and `sdo` are high, and `busy`, `done`, `tx_ready` and `rx_valid` are low.
- R2: A transfer started with `cfg_bits` = N (1..255) produces exactly N falling edges on `sclk`. N = 0 produces 256. The transfer returns ceil(N/8) received bytes.
- R3: Each half period of `sclk` lasts max(`cfg_div`, DIV_MIN)+1 clock cycles, with DIV_MIN = 1 by default. `sclk` is high whenever no bit is in flight. `sdo` changes only together with a falling `sclk` edge.
- R4: With `cfg_msb_first` = 1, the first bit driven is `tx_data[7]`. With 0, it is `tx_data[0]`.
- R5: After each byte, `rx_valid` pulses for one cycle with the received bits in `rx_data`. These bits are `sdi` as sampled on the rising edges.
- R6: `tx_ready` is high only while the block waits at a byte boundary with `pause` low. A byte is taken in the cycle where `tx_valid` and `tx_ready` are both high, and exactly ceil(N/8) bytes are taken per transfer.
- R7: While `pause` is high at a byte boundary, `sclk` stays high and no byte is taken. Releasing `pause` resumes the transfer with no lost or repeated bits.
- R8: While `tx_valid` is low at a byte boundary, the clock holds high and `tx_ready` stays high until a byte is offered.
- R9: When the final bit completes, `busy` falls and `done` rises in the same cycle. `done` stays high until the next accepted start, which clears it.
- R10: A `start` pulse while `busy` is high is ignored. The transfer in flight keeps its length.
- R11: A partial last byte of k bits sends `tx_data[7:8-k]` (MSB first) or `tx_data[k-1:0]` (LSB first). It returns its received bits right-justified in `rx_data`, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous-assert reset |
| cfg_div | input | DIV_W | Half-period divider setting, clamped to DIV_MIN |
| cfg_bits | input | CNT_W | Transfer length in bits, 0 meaning 2^CNT_W |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| start | input | 1 | Start pulse, taken only while idle |
| pause | input | 1 | Hold the transfer at the next byte boundary |
| tx_data | input | BYTE_W | Next transmit byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Block waits for a transmit byte |
| rx_data | output | BYTE_W | Received byte, right-justified when partial |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A wrong bit counter shows at once as an extra or a missing `sclk` falling edge. It also shows as a wrong count of `rx_valid` strobes at the end of the transfer. A wrong divider shows within the first low phase of `sclk`. A shift-order or justification fault corrupts the first partial byte returned over a loopback of `sdo` to `sdi`. A boundary-wait fault shows as `sclk` activity or an accepted byte while `pause` is held, within a few divider periods of the boundary.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_SHIFT = 2'd2
   } ssp_state_e;
endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
   parameter int DIV_W   = 8,
   parameter int DIV_MIN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam logic [DIV_W-1:0] MIN_V = DIV_W'(DIV_MIN);

   generate
      if (DIV_MIN < 1 || DIV_MIN >= (1 << DIV_W)) begin : g_bad_min
         $error("ssp_baud: DIV_MIN out of range");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   assign lim  = (div < MIN_V) ? MIN_V : div;
   assign tick = run && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                 cnt <= cnt + DIV_W'(1);
   end

   // R3
   baud_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
   parameter int BYTE_W = 8,
   parameter int NB_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msb,
   input  logic              load,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              fall,
   input  logic              rise,
   input  logic              sdi,
   input  logic              byte_end,
   input  logic [NB_W-1:0]   nbits,
   output logic              sdo,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid
);
   generate
      if ((1 << NB_W) <= BYTE_W) begin : g_bad_nb
         $error("ssp_shift: NB_W too narrow for BYTE_W");
      end
   endgenerate

   logic [BYTE_W-1:0] tx_sr;
   logic [BYTE_W-1:0] tx_nxt;
   logic [BYTE_W-1:0] rx_sr;
   logic [NB_W-1:0]   shamt;

   assign tx_nxt = msb ? (tx_sr << 1) : (tx_sr >> 1);
   assign shamt  = NB_W'(BYTE_W) - nbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr <= '0;
         sdo   <= 1'b1;
      end else if (load) begin
         tx_sr <= tx_data;
         sdo   <= msb ? tx_data[BYTE_W-1] : tx_data[0];
      end else if (fall) begin
         tx_sr <= tx_nxt;
         sdo   <= msb ? tx_nxt[BYTE_W-1] : tx_nxt[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sr    <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= byte_end;
         if (load)
            rx_sr <= '0;
         else if (rise)
            rx_sr <= msb ? {rx_sr[BYTE_W-2:0], sdi} : {sdi, rx_sr[BYTE_W-1:1]};
         if (byte_end)
            rx_data <= msb ? rx_sr : (rx_sr >> shamt);
      end
   end

   // R3
   sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load || fall) |=> $stable(sdo));
   // R5
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
   import ssp_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 8,
   parameter int NB_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] cfg_bits,
   input  logic             cfg_msb,
   input  logic             pause,
   input  logic             tx_valid,
   input  logic             tick,
   output logic             run,
   output logic             sclk,
   output logic             busy,
   output logic             done,
   output logic             tx_ready,
   output logic             load,
   output logic             rise,
   output logic             fall,
   output logic             byte_end,
   output logic [NB_W-1:0]  nbits,
   output logic             msb
);
   localparam int REM_W = CNT_W + 1;

   generate
      if (BYTE_W > (1 << CNT_W)) begin : g_bad_cnt
         $error("ssp_seq: CNT_W too narrow for one byte");
      end
   endgenerate

   ssp_state_e        state;
   logic [REM_W-1:0]  remain;
   logic [REM_W-1:0]  start_len;
   logic [NB_W-1:0]   bcnt;
   logic [NB_W-1:0]   nbits_next;
   logic              last_byte;

   assign start_len  = (cfg_bits == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cfg_bits};
   assign nbits_next = (remain >= REM_W'(BYTE_W)) ? NB_W'(BYTE_W) : NB_W'(remain);
   assign last_byte  = (remain == REM_W'(nbits));

   assign run      = (state == ST_SHIFT);
   assign busy     = (state != ST_IDLE);
   assign tx_ready = (state == ST_LOAD) && !pause;
   assign load     = tx_ready && tx_valid;
   assign rise     = run && tick && !sclk;
   assign fall     = run && tick && sclk && (bcnt != nbits);
   assign byte_end = run && tick && sclk && (bcnt == nbits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         remain <= '0;
         bcnt   <= '0;
         nbits  <= '0;
         sclk   <= 1'b1;
         msb    <= 1'b1;
         done   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               remain <= start_len;
               msb    <= cfg_msb;
               done   <= 1'b0;
               state  <= ST_LOAD;
            end
            ST_LOAD: if (load) begin
               sclk  <= 1'b0;
               bcnt  <= '0;
               nbits <= nbits_next;
               state <= ST_SHIFT;
            end
            ST_SHIFT: if (tick) begin
               if (!sclk) begin
                  sclk <= 1'b1;
                  bcnt <= bcnt + NB_W'(1);
               end else if (bcnt == nbits) begin
                  remain <= remain - REM_W'(nbits);
                  if (last_byte) begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     state <= ST_LOAD;
                  end
               end else begin
                  sclk <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R7
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOAD && pause) |=> (state == ST_LOAD && sclk));
   // R3
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_SHIFT) |-> sclk);
   // R3
   sclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT && !tick) |=> $stable(sclk));
   // R2
   bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT) |-> (bcnt <= nbits && nbits != '0));
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (state == ST_IDLE));
endmodule

// File: rtl/ssp_autoxfer.sv
module ssp_autoxfer #(
   parameter int BYTE_W  = 8,
   parameter int CNT_W   = 8,
   parameter int DIV_W   = 8,
   parameter int DIV_MIN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [CNT_W-1:0]  cfg_bits,
   input  logic              cfg_msb_first,
   input  logic              start,
   input  logic              pause,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              busy,
   output logic              done,
   output logic              sclk,
   output logic              sdo,
   input  logic              sdi
);
   localparam int NB_W = $clog2(BYTE_W + 1);

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("ssp_autoxfer: BYTE_W must be at least 2");
      end
   endgenerate

   logic            run, tick, load, rise, fall, byte_end, msb;
   logic [NB_W-1:0] nbits;

   ssp_baud #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div), .tick(tick)
   );

   ssp_seq #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .NB_W(NB_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_bits(cfg_bits),
      .cfg_msb(cfg_msb_first), .pause(pause), .tx_valid(tx_valid),
      .tick(tick), .run(run), .sclk(sclk), .busy(busy), .done(done),
      .tx_ready(tx_ready), .load(load), .rise(rise), .fall(fall),
      .byte_end(byte_end), .nbits(nbits), .msb(msb)
   );

   ssp_shift #(.BYTE_W(BYTE_W), .NB_W(NB_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .msb(msb), .load(load), .tx_data(tx_data),
      .fall(fall), .rise(rise), .sdi(sdi), .byte_end(byte_end),
      .nbits(nbits), .sdo(sdo), .rx_data(rx_data), .rx_valid(rx_valid)
   );
endmodule

// File: tb/sim_ssp_autoxfer.sv
module sim_ssp_autoxfer;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 9;
   // {bits[16:9], msb[8], div[7:0]}
   localparam logic [16:0] VEC [NVEC] = '{
      {8'd8,   1'b1, 8'd3},
      {8'd8,   1'b0, 8'd0},
      {8'd13,  1'b1, 8'd2},
      {8'd13,  1'b0, 8'd1},
      {8'd1,   1'b1, 8'd4},
      {8'd1,   1'b0, 8'd1},
      {8'd0,   1'b1, 8'd1},
      {8'd255, 1'b0, 8'd2},
      {8'd24,  1'b1, 8'd7}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [7:0] cfg_div = 8'd1, cfg_bits = 8'd8, tx_data = 8'h00, rx_data;
   logic cfg_msb_first = 1'b1, start = 1'b0, pause = 1'b0, tx_valid = 1'b0;
   logic tx_ready, rx_valid, busy, done, sclk, sdo, sdi, lb = 1'b1;

   assign sdi = lb ? sdo : 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   ssp_autoxfer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_bits(cfg_bits),
      .cfg_msb_first(cfg_msb_first), .start(start), .pause(pause),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .done(done),
      .sclk(sclk), .sdo(sdo), .sdi(sdi)
   );

   int tests = 0, failed = 0;
   int tx_idx = 0, rx_cnt = 0, falls = 0, lowcnt = 0, last_low = 0;
   int total = 8, cur_h = 2;
   bit cur_msb = 1'b1, acc_pend = 1'b0, sclk_q = 1'b1, first_sdo = 1'b0;

   function automatic logic [7:0] pat(input int i);
      return 8'h35 ^ 8'(i * 59);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         failed++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   // feeder and monitor, all at the falling clock edge
   always @(negedge clk) begin
      if (acc_pend) begin tx_idx++; tx_data = pat(tx_idx); end
      acc_pend = tx_valid && tx_ready;
      if (sclk_q && !sclk) begin
         if (falls == 0) first_sdo = sdo;
         falls++;
      end
      if (!sclk) lowcnt++;
      else if (lowcnt != 0) begin last_low = lowcnt; lowcnt = 0; end
      sclk_q = sclk;
      if (rx_valid) begin
         int k;
         logic [7:0] exp, src;
         k = (total - 8*rx_cnt >= 8) ? 8 : total - 8*rx_cnt;
         src = pat(rx_cnt);
         if (!lb) exp = 8'((1 << k) - 1);
         else if (cur_msb) exp = src >> (8 - k);
         else exp = src & 8'((1 << k) - 1);
         // R5 for full bytes, R11 for a partial last byte
         chk(rx_data == exp, (k < 8) ? "R11 partial rx" : "R5 rx byte", rx_data, exp);
         rx_cnt++;
      end
   end

   task automatic begin_xfer(input int bits, input bit msb, input int div,
                             input bit loop, input bit valid);
      cfg_bits = 8'(bits); cfg_msb_first = msb; cfg_div = 8'(div); lb = loop;
      total = (bits == 0) ? 256 : bits; cur_msb = msb;
      cur_h = ((div < 1) ? 1 : div) + 1;
      tx_idx = 0; tx_data = pat(0); rx_cnt = 0; falls = 0;
      tx_valid = valid; start = 1'b1;
      step();
      start = 1'b0;
      // R9 done cleared by start
      chk(!done && busy, "R9 start clears done", done, 0);
   endtask

   task automatic end_xfer();
      int guard = 0, nb;
      nb = (total + 7) / 8;
      while (busy && guard < 20000) begin step(); guard++; end
      step();
      // R2 bit count and byte count
      chk(falls == total, "R2 sclk falls", falls, total);
      chk(rx_cnt == nb, "R2 rx bytes", rx_cnt, nb);
      // R3 half period
      chk(last_low == cur_h, "R3 half period", last_low, cur_h);
      chk(sclk == 1'b1, "R3 idle high", sclk, 1);
      // R4 first bit order
      chk(first_sdo == (cur_msb ? pat(0)[7] : pat(0)[0]), "R4 first bit",
          first_sdo, cur_msb ? pat(0)[7] : pat(0)[0]);
      // R6 bytes taken
      chk(tx_idx == nb, "R6 bytes taken", tx_idx, nb);
      // R9 done after end
      chk(done && !busy, "R9 done", done, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++; failed++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      step(3);
      // R1 reset state
      chk(sclk && sdo && !busy && !done && !tx_ready && !rx_valid, "R1 reset",
          {sclk, sdo, busy, done, tx_ready, rx_valid}, 6'b110000);
      rst_n = 1'b1;
      step(2);

      for (int i = 0; i < NVEC; i++) begin
         begin_xfer(int'(VEC[i][16:9]), VEC[i][8], int'(VEC[i][7:0]), 1'b1, 1'b1);
         end_xfer();
      end

      // R11 justification with sdi held high, both orders
      begin_xfer(3, 1'b0, 1, 1'b0, 1'b1); end_xfer();
      begin_xfer(3, 1'b1, 2, 1'b0, 1'b1); end_xfer();

      // R9 done persists while idle
      step(5);
      chk(done == 1'b1, "R9 done holds", done, 1);

      // R8 stall while no tx byte offered
      begin_xfer(10, 1'b1, 1, 1'b1, 1'b0);
      step(20);
      chk(falls == 0 && sclk, "R8 stall no clock", falls, 0);
      chk(tx_ready == 1'b1, "R6 ready while waiting", tx_ready, 1);
      tx_valid = 1'b1;
      end_xfer();

      // R7 pause before first byte and at a mid boundary
      pause = 1'b1;
      begin_xfer(20, 1'b1, 1, 1'b1, 1'b1);
      step(30);
      chk(falls == 0 && sclk, "R7 paused at start", falls, 0);
      chk(tx_ready == 1'b0 && busy, "R7 not ready", tx_ready, 0);
      pause = 1'b0;
      step(3);
      pause = 1'b1;
      begin
         int g = 0;
         while (rx_cnt < 1 && g < 5000) begin step(); g++; end
      end
      step(30);
      chk(falls == 8 && sclk, "R7 held at boundary", falls, 8);
      chk(rx_cnt == 1 && tx_idx == 1, "R7 no byte taken", tx_idx, 1);
      pause = 1'b0;
      end_xfer();

      // R10 start ignored while busy
      begin_xfer(16, 1'b1, 2, 1'b1, 1'b1);
      step(10);
      cfg_bits = 8'd3; start = 1'b1;
      step();
      start = 1'b0;
      end_xfer();
      chk(falls == 16, "R10 length kept", falls, 16);

      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end
endmodule